// File: doc/BRIEF.md
# Two-Wire Memory Slave Controller

This block is the serial front end of a 256-byte memory on a two-wire bus. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and compares the first byte of every transfer against a device address set by a parameter. In write mode it takes one word address byte and then any number of data bytes, acknowledging each one. Every data byte is handed to an external page write engine over a byte interface. That interface carries a valid strobe, an address and the data. It also carries a commit pulse when the master closes with a stop, and an abort pulse when the master restarts instead.

In read mode the block fetches bytes from the memory at its current-address pointer and shifts them out MSB first. It moves on to the next byte while the master acknowledges, and it stops driving after a not-acknowledge. The pointer persists between transactions, so a master can perform current-address reads, random reads and sequential reads. A random read is a dummy write of the word address followed by a repeated start with the read bit set. While the engine reports busy, the block acknowledges nothing, which lets a master poll for the end of an internal write. The data output is open-drain style: a single enable that pulls the line low.

Top module: `twsSlave`

## Requirements
- R1: A start condition (data falling while clock is high) from any state discards the bit count and begins a new device-address byte. A stop condition (data rising while clock is high) returns the block to idle with the line released.
- R2: The first byte after a start is acknowledged only when its upper seven bits equal DEV_ADDR. Its bit 0 selects write (0) or read (1). On a mismatch the line is never pulled low until the next start.
- R3: Every accepted address, word-address or data byte is acknowledged by pulling the line low for the ninth clock. The block never pulls the line low while the master is sending bits.
- R4: While busyIn is high, the device-address byte is not acknowledged, even when it matches. Once busyIn is low, the same byte is acknowledged.
- R5: In write mode the second byte is the word address. Each later data byte produces one wrValid pulse with its target address and data. A stop after one or more data bytes gives one wrCommit pulse. A start in place of that stop gives one wrAbort pulse and no commit, so the memory keeps its old contents.
- R6: Successive data bytes in one write go to addresses that advance only in the low log2(PAGE_BYTES) bits and wrap inside the aligned page. A ninth byte therefore targets the same address as the first.
- R7: In read mode the byte at rdAddr is sent MSB first. A master acknowledge (0) after a byte starts the next byte; a not-acknowledge (1) ends output with the line released.
- R8: The address pointer resets to 0. After each byte read it becomes that byte's address plus one, and it wraps from 255 to 0. After each data byte received it becomes that byte's target address plus one, across the full space.
- R9: A write that ends after the word address, followed by a repeated start with the read bit set, reads from that word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaDriveLow | output | 1 | When high, the data line is pulled low |
| rdAddr | output | ADDR_W | Current-address pointer, memory read address |
| rdData | input | 8 | Memory byte at rdAddr |
| wrValid | output | 1 | One-cycle strobe: a data byte was received |
| wrAddr | output | ADDR_W | Target address of the strobed byte |
| wrData | output | 8 | Strobed data byte |
| wrCommit | output | 1 | One-cycle pulse: stop ended a write with data |
| wrAbort | output | 1 | One-cycle pulse: restart discarded pending data |
| busyIn | input | 1 | Engine is performing its internal write |

## Verification
The bench builds the block with its defaults: DEV_ADDR 0x50, an 8-bit address, 8-byte pages and two synchronizer stages. With an 8-bit address, sequential reads that cross from 255 to 0 come within reach. With 8-byte pages, a four-byte write from 0x06 wraps to 0x00, and a ten-byte write overwrites the first two bytes of its page. A behavioural engine holds the memory and raises busy for several hundred cycles after each commit, long enough for polls to be refused before one is accepted.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_WADR, ST_ADRACK,
    ST_WDAT, ST_DATACK, ST_TX, ST_MACK
  } ctrlState_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic clrBits;   // zero bit counter
    logic shiftIn;   // shift sampled bit into receive register
    logic countBit;  // count a transmitted bit
    logic loadTx;    // load memory byte, advance pointer
    logic shiftTx;   // move to next transmit bit
    logic setPtr;    // take word address into both pointers
    logic emitByte;  // present received byte to the engine
    logic commit;    // stop after write data
    logic abort;     // restart discarding write data
  } ctrlStrobe_t;

endpackage

// File: rtl/twsDpath.sv
module twsDpath
  import twsPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobe_t       stb,
  output logic              evStart,
  output logic              evStop,
  output logic              evRise,
  output logic              evFall,
  output logic              sdaNow,
  output logic              byteFull,
  output logic [7:0]        shByte,
  output logic              txNext,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit,
  output logic              wrAbort
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic [ADDR_W-1:0] ptr, wrPtr;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else if (g == 0) begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end else begin
          sclSync[g] <= sclSync[(g == 0) ? 0 : g-1];
          sdaSync[g] <= sdaSync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign evStart = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evStop  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign evRise  = sclNow & ~sclPrev;
  assign evFall  = ~sclNow & sclPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shByte <= '0;
    end else if (stb.clrBits) begin
      bitCnt <= '0;
    end else if (stb.loadTx) begin
      bitCnt <= '0;
      shByte <= rdData;
    end else if (stb.shiftIn) begin
      bitCnt <= bitCnt + 4'd1;
      shByte <= {shByte[6:0], sdaNow};
    end else if (stb.countBit) begin
      bitCnt <= bitCnt + 4'd1;
    end else if (stb.shiftTx) begin
      shByte <= {shByte[6:0], 1'b0};
    end
  end

  assign byteFull = (bitCnt == 4'd8);
  assign txNext   = shByte[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      wrPtr    <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrCommit <= 1'b0;
      wrAbort  <= 1'b0;
    end else begin
      wrValid  <= stb.emitByte;
      wrCommit <= stb.commit;
      wrAbort  <= stb.abort;
      if (stb.setPtr) begin
        ptr   <= shByte[ADDR_W-1:0];
        wrPtr <= shByte[ADDR_W-1:0];
      end else if (stb.loadTx) begin
        ptr <= ptr + A_ONE;
      end else if (stb.emitByte) begin
        wrAddr <= wrPtr;
        wrData <= shByte;
        ptr    <= wrPtr + A_ONE;
        wrPtr  <= {wrPtr[ADDR_W-1:PAGE_W], wrPtr[PAGE_W-1:0] + P_ONE};
      end
    end
  end

  assign rdAddr = ptr;

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> (bitCnt == 4'd0));
  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitByte |=> (wrPtr[ADDR_W-1:PAGE_W] == $past(wrPtr[ADDR_W-1:PAGE_W])));
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> (ptr == $past(ptr) + A_ONE));
  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrCommit && wrAbort));

endmodule

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evStart,
  input  logic        evStop,
  input  logic        evRise,
  input  logic        evFall,
  input  logic        sdaNow,
  input  logic        byteFull,
  input  logic [7:0]  shByte,
  input  logic        txNext,
  input  logic        rdMsb,
  input  logic        busyIn,
  output ctrlStrobe_t stb,
  output logic        sdaDriveLow
);
  ctrlState_e state, nState;
  logic nDrive, readMode, nRead, pending, nPend, masterAck, nMAck;

  always_comb begin
    nState = state;
    nDrive = sdaDriveLow;
    nRead  = readMode;
    nPend  = pending;
    nMAck  = masterAck;
    stb    = '0;
    if (evStart) begin
      stb.abort   = pending;
      stb.clrBits = 1'b1;
      nPend  = 1'b0;
      nDrive = 1'b0;
      nState = ST_DEV;
    end else if (evStop) begin
      stb.commit  = pending;
      stb.clrBits = 1'b1;
      nPend  = 1'b0;
      nDrive = 1'b0;
      nState = ST_IDLE;
    end else begin
      case (state)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (evRise && !byteFull) stb.shiftIn = 1'b1;
          if (evFall && byteFull) begin
            if (state == ST_DEV) begin
              if (shByte[7:1] == DEV_ADDR && !busyIn) begin
                nDrive = 1'b1;
                nRead  = shByte[0];
                nState = ST_DEVACK;
              end else begin
                nState = ST_IDLE;
              end
            end else if (state == ST_WADR) begin
              stb.setPtr = 1'b1;
              nDrive = 1'b1;
              nState = ST_ADRACK;
            end else begin
              stb.emitByte = 1'b1;
              nPend  = 1'b1;
              nDrive = 1'b1;
              nState = ST_DATACK;
            end
          end
        end
        ST_DEVACK: if (evFall) begin
          if (readMode) begin
            stb.loadTx = 1'b1;
            nDrive = ~rdMsb;
            nState = ST_TX;
          end else begin
            stb.clrBits = 1'b1;
            nDrive = 1'b0;
            nState = ST_WADR;
          end
        end
        ST_ADRACK, ST_DATACK: if (evFall) begin
          stb.clrBits = 1'b1;
          nDrive = 1'b0;
          nState = ST_WDAT;
        end
        ST_TX: begin
          if (evRise && !byteFull) stb.countBit = 1'b1;
          if (evFall) begin
            if (byteFull) begin
              nDrive = 1'b0;
              nState = ST_MACK;
            end else begin
              stb.shiftTx = 1'b1;
              nDrive = ~txNext;
            end
          end
        end
        ST_MACK: begin
          if (evRise) nMAck = ~sdaNow;
          if (evFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              nDrive = ~rdMsb;
              nState = ST_TX;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdaDriveLow <= 1'b0;
      readMode    <= 1'b0;
      pending     <= 1'b0;
      masterAck   <= 1'b0;
    end else begin
      state       <= nState;
      sdaDriveLow <= nDrive;
      readMode    <= nRead;
      pending     <= nPend;
      masterAck   <= nMAck;
    end
  end

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDriveLow);
  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && evFall && byteFull && busyIn && !evStart && !evStop)
      |=> (state == ST_IDLE && !sdaDriveLow));
  assert_ack_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_DEVACK, ST_ADRACK, ST_DATACK}) |-> sdaDriveLow);
  assert_master_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_WADR, ST_WDAT, ST_MACK}) |-> !sdaDriveLow);

endmodule

// File: rtl/twsSlave.sv
module twsSlave
  import twsPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_BYTES  = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit,
  output logic              wrAbort,
  input  logic              busyIn
);
  ctrlStrobe_t stb;
  logic evStart, evStop, evRise, evFall, sdaNow, byteFull, txNext;
  logic [7:0] shByte;

  twsDpath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .evStart(evStart), .evStop(evStop), .evRise(evRise), .evFall(evFall),
    .sdaNow(sdaNow), .byteFull(byteFull), .shByte(shByte), .txNext(txNext),
    .rdAddr(rdAddr), .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit), .wrAbort(wrAbort)
  );

  twsCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evRise(evRise), .evFall(evFall), .sdaNow(sdaNow), .byteFull(byteFull),
    .shByte(shByte), .txNext(txNext), .rdMsb(rdData[7]), .busyIn(busyIn),
    .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/tb_twsSlave.sv
module tb_twsSlave;
  localparam int QC = 10;
  localparam logic [6:0] DEV = 7'h50;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow, wrValid, wrCommit, wrAbort, busyIn;
  logic [7:0] rdAddr, wrAddr, wrData, rdData;
  wire sdaLine = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  twsSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .rdAddr(rdAddr), .rdData(rdData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrCommit(wrCommit), .wrAbort(wrAbort), .busyIn(busyIn)
  );

  int total = 0, bad = 0, stray = 0, commits = 0, aborts = 0, busyCnt = 0;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] pendA[$], pendD[$], expA[$], expD[$];
  logic [7:0] expPtr = 8'h00;

  assign rdData = mem[rdAddr];
  assign busyIn = (busyCnt != 0);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural page engine
  always @(posedge clk) begin
    if (busyCnt > 0) busyCnt = busyCnt - 1;
    if (wrValid) begin pendA.push_back(wrAddr); pendD.push_back(wrData); end
    if (wrCommit) begin
      commits++;
      foreach (pendA[i]) mem[pendA[i]] = pendD[i];
      pendA.delete(); pendD.delete();
      busyCnt = BUSY_CYC;
    end
    if (wrAbort) begin aborts++; pendA.delete(); pendD.delete(); end
  end

  // per-clock comparison of the byte interface with the expected stream
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (expA.size() == 0) check(0, "R5 unexpected byte", wrAddr, 0);
      else begin
        logic [7:0] ea, ed;
        ea = expA.pop_front(); ed = expD.pop_front();
        check(wrAddr == ea, "R6 byte address", wrAddr, ea);
        check(wrData == ed, "R5 byte data", wrData, ed);
      end
    end
  end

  task automatic waitQ; repeat (QC) @(negedge clk); endtask

  task automatic startC;
    sdaM = 1'b1; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b0; waitQ; sclM = 1'b0; waitQ;
  endtask

  task automatic stopC;
    sdaM = 1'b0; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b1; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ; sclM = 1'b1; waitQ;
      if (sdaDriveLow) stray++;
      waitQ; sclM = 1'b0; waitQ;
    end
    sdaM = 1'b1; waitQ; sclM = 1'b1; waitQ;
    ack = !sdaLine;
    waitQ; sclM = 1'b0; waitQ;
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ; sclM = 1'b1; waitQ; b[i] = sdaLine; waitQ; sclM = 1'b0;
    end
    waitQ; sdaM = !mAck; waitQ; sclM = 1'b1; waitQ; waitQ; sclM = 1'b0; waitQ;
  endtask

  task automatic writeSeq(input logic [7:0] a, input logic [7:0] d[$], input bit useStop);
    bit ack;
    logic [7:0] pa;
    startC;
    sendByte({DEV, 1'b0}, ack); check(ack, "R2 write address ack", ack, 1);
    sendByte(a, ack);           check(ack, "R3 word address ack", ack, 1);
    foreach (d[k]) begin
      pa = (a & 8'hF8) | ((a + 8'(k)) & 8'h07);
      expA.push_back(pa); expD.push_back(d[k]);
      sendByte(d[k], ack); check(ack, "R3 data ack", ack, 1);
      if (useStop) expMem[pa] = d[k];
      expPtr = pa + 8'd1;
    end
    if (useStop) stopC;
  endtask

  task automatic pollReady(output int nacks);
    bit ack;
    nacks = 0;
    for (int t = 0; t < 40; t++) begin
      startC; sendByte({DEV, 1'b0}, ack); stopC;
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic readOut(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      readByte(i != n-1, b);
      check(b == expMem[expPtr], tag, b, expMem[expPtr]);
      expPtr = expPtr + 8'd1;
    end
    stopC;
  endtask

  task automatic randRead(input logic [7:0] a, input int n);
    bit ack;
    startC;
    sendByte({DEV, 1'b0}, ack); check(ack, "R9 dummy write ack", ack, 1);
    sendByte(a, ack);           check(ack, "R9 word address ack", ack, 1);
    startC;
    sendByte({DEV, 1'b1}, ack); check(ack, "R2 read address ack", ack, 1);
    expPtr = a;
    readOut(n, "R9 R7 random read data");
  endtask

  task automatic curRead(input int n);
    bit ack;
    startC;
    sendByte({DEV, 1'b1}, ack); check(ack, "R2 read address ack", ack, 1);
    readOut(n, "R8 current address data");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nacks;
    bit ack;
    logic [7:0] q[$];
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'hA5; expMem[i] = 8'(i) ^ 8'hA5; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdaDriveLow == 0, "R1 reset released line", sdaDriveLow, 0);
    check(wrValid == 0 && wrCommit == 0 && wrAbort == 0, "R5 reset strobes", wrValid, 0);
    check(rdAddr == 0, "R8 reset pointer", rdAddr, 0);

    // R2: foreign address ignored, following byte not acknowledged
    startC;
    sendByte({7'h51, 1'b0}, ack); check(!ack, "R2 mismatch nack", ack, 0);
    sendByte(8'h12, ack);         check(!ack, "R2 idle after mismatch", ack, 0);
    stopC;

    // R5 byte write, R4 polling
    q = {8'h5A};
    writeSeq(8'h10, q, 1);
    pollReady(nacks);
    check(nacks >= 1, "R4 nack while busy", nacks, 1);
    check(nacks < 40, "R4 ack after busy", nacks, 39);
    randRead(8'h10, 1);

    // R6 page wrap inside a page
    q = {8'h11, 8'h22, 8'h33, 8'h44};
    writeSeq(8'h06, q, 1);
    pollReady(nacks);
    randRead(8'h00, 2);
    randRead(8'h06, 2);

    // R6 ten bytes: first two overwritten
    q = {8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
    writeSeq(8'h20, q, 1);
    pollReady(nacks);
    randRead(8'h20, 8);

    // R5 R1 restart instead of stop discards data
    q = {8'hEE};
    writeSeq(8'h30, q, 0);
    curRead(1);
    check(aborts == 1, "R5 abort pulse", aborts, 1);
    check(!busyIn, "R5 no commit on abort", busyIn, 0);
    randRead(8'h30, 1);

    // R8 pointer after write
    q = {8'h9C};
    writeSeq(8'h47, q, 1);
    pollReady(nacks);
    curRead(1);

    // R8 sequential wrap 255 -> 0, then current read continues
    randRead(8'hFE, 4);
    curRead(2);

    check(commits == 4, "R5 commit count", commits, 4);
    check(expA.size() == 0, "R5 all bytes strobed", expA.size(), 0);
    check(stray == 0, "R3 no drive during master bits", stray, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule